// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

This block counts activity on one input pin in a 16-bit accumulator and picks the clock that advances a neighbouring timer counter. It has two counting modes. In event mode the accumulator advances once for each edge of the chosen polarity on the pin. In gated mode the pin is treated as a gate. While the gate is at its active level, the accumulator advances on each tick of an external time base.

The timer-count-enable output `tmr_tick` follows one of four sources, chosen by a two-bit field. The sources are the prescaler enable, the accumulator's own advance pulse, that pulse divided by 256 (the carry out of the low byte), and that pulse divided by 65536 (the accumulator wrap). When the accumulator is disabled, the prescaler enable is always used.

Two status flags report an accumulator wrap and a pin edge. Software clears them by writing ones to them, or by any access to the count register when fast clearing is switched on. The host uses a plain register port. The read data is combinational on the address, a write takes effect at the clock edge, and there is no back-pressure.

Top module: `pulse_accum`

## Requirements
- R1: After reset, the control register, the count and both flags read 0, and `tmr_tick` equals `presc_tick`.
- R2: The register at address 0 is the control register. Its bit 0 enables counting, bit 1 selects gated mode, bit 2 inverts the polarity, bits 4:3 are the clock select and bit 5 enables fast clearing. Other bits read 0. Address 1 is the count and reads and writes all 16 bits. Address 2 holds the wrap flag in bit 1 and the edge flag in bit 0, with every other bit read as 0. Address 3 reads 0.
- R3: The pin passes through two synchronising flops. A pin level set up before clock edge k changes the count at edge k+2.
- R4: In event mode, when enabled, the count advances by one per rising pin edge if bit 2 is 0, or per falling pin edge if bit 2 is 1.
- R5: In gated mode, when enabled, the count advances on each cycle in which `tbase_tick` is 1 and the synchronised pin is at its active level. The active level is high if bit 2 is 0 and low if bit 2 is 1.
- R6: An advance from 0xFFFF gives 0x0000 and sets the wrap flag.
- R7: The edge flag sets on the counted edge in event mode, and on the trailing edge of the gate (the change from the active level to the inactive level) in gated mode.
- R8: Writing a 1 to a flag bit at address 2 clears that flag, and writing a 0 to it leaves the flag unchanged. A set in the same cycle as a clear wins.
- R9: With fast clearing on, any read or write of address 1 clears both flags. With fast clearing off, such an access leaves the flags unchanged.
- R10: With counting enabled, clock select 0 passes `presc_tick`, 1 passes the advance pulse, 2 passes an advance from a count whose low byte is 0xFF, and 3 passes an advance from 0xFFFF.
- R11: With counting disabled, `tmr_tick` equals `presc_tick` whatever the clock select holds, the count does not advance and no flag sets.
- R12: A control write changes the behaviour from the next cycle on, with no wait for a period boundary.
- R13: A write to the count in the same cycle as an advance loads the written value, and that advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous event or gate pin |
| presc_tick | input | 1 | Prescaler clock enable |
| tbase_tick | input | 1 | Time-base tick for gated mode |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on address |
| tmr_tick | output | 1 | Timer counter clock enable |

## Verification
Event counting is driven with slow pin toggles under both polarities, so a design that counts the wrong edge, or both edges, shows up in the count. Gated mode is driven with the time base ticking every cycle and every other cycle, and with gates that open and close, which separates level gating from edge counting and shows whether the trailing-edge flag is correct. The count is preloaded near 0x00FF and 0xFFFF under each clock select, which checks the three divided outputs apart from one another. A long phase of mixed random pin activity, register accesses and control writes then catches same-cycle collisions between set and clear, and between load and advance.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam int LO_W   = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CNT  = 2'd1,
    A_FLG  = 2'd2,
    A_RSV  = 2'd3
  } pa_addr_e;

  typedef enum logic [1:0] {
    CS_PRESC    = 2'd0,
    CS_DIRECT   = 2'd1,
    CS_DIV_LO   = 2'd2,
    CS_DIV_FULL = 2'd3
  } pa_clksel_e;

  typedef struct packed {
    logic       fast_clr;
    pa_clksel_e clk_sel;
    logic       pol;
    logic       gated;
    logic       en;
  } pa_ctrl_t;

  localparam int CTRL_W = $bits(pa_ctrl_t);
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
  end

  assign lvl  = sh_q[SYNC_STAGES-1];
  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

  AST_RISE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(pin, SYNC_STAGES)); // R3
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int W    = 16,
  parameter int LO_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         lo_carry,
  output logic         wrap
);
  logic adv;

  assign adv      = inc & ~load;
  assign lo_carry = adv & (&cnt[LO_W-1:0]);
  assign wrap     = adv & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (&cnt)) |=> (cnt == '0)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R13
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(cnt)); // R11
endmodule

// File: rtl/pa_clk_sel.sv
module pa_clk_sel
  import pa_pkg::*;
(
  input  logic       en,
  input  pa_clksel_e sel,
  input  logic       presc_tick,
  input  logic       direct,
  input  logic       div_lo,
  input  logic       div_full,
  output logic       tick
);
  always_comb begin
    if (!en) tick = presc_tick;
    else begin
      case (sel)
        CS_PRESC:    tick = presc_tick;
        CS_DIRECT:   tick = direct;
        CS_DIV_LO:   tick = div_lo;
        default:     tick = div_full;
      endcase
    end
  end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              presc_tick,
  input  logic              tbase_tick,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tmr_tick
);
  pa_ctrl_t   ctrl_q;
  pa_addr_e   addr;
  logic       lvl, rise, fall;
  logic       act_edge, trail_edge, gate_on;
  logic       inc, load, lo_carry, wrap;
  logic [CNT_W-1:0] cnt;
  logic       ovf_q, edg_q;
  logic       ovf_set, edg_set, cnt_access;
  logic       ovf_clr, edg_clr;

  assign addr = pa_addr_e'(bus_addr);

  pa_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign act_edge   = ctrl_q.pol ? fall : rise;
  assign trail_edge = ctrl_q.pol ? rise : fall;
  assign gate_on    = lvl ^ ctrl_q.pol;
  assign inc  = ctrl_q.en & (ctrl_q.gated ? (tbase_tick & gate_on) : act_edge);
  assign load = bus_wr & (addr == A_CNT);

  pa_counter #(.W(CNT_W), .LO_W(LO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .load(load),
    .load_val(bus_wdata[CNT_W-1:0]),
    .cnt(cnt), .lo_carry(lo_carry), .wrap(wrap)
  );

  pa_clk_sel u_sel (
    .en(ctrl_q.en), .sel(ctrl_q.clk_sel), .presc_tick(presc_tick),
    .direct(inc & ~load), .div_lo(lo_carry), .div_full(wrap),
    .tick(tmr_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= '0;
    else if (bus_wr && (addr == A_CTRL))     ctrl_q <= pa_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  assign cnt_access = ctrl_q.fast_clr & (bus_wr | bus_rd) & (addr == A_CNT);
  assign ovf_set = wrap;
  assign edg_set = ctrl_q.en & (ctrl_q.gated ? trail_edge : act_edge);
  assign ovf_clr = cnt_access | (bus_wr & (addr == A_FLG) & bus_wdata[1]);
  assign edg_clr = cnt_access | (bus_wr & (addr == A_FLG) & bus_wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      edg_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
      edg_q <= edg_set | (edg_q & ~edg_clr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_CNT:   bus_rdata[CNT_W-1:0]  = cnt;
      A_FLG:   bus_rdata[1:0]        = {ovf_q, edg_q};
      default: bus_rdata = '0;
    endcase
  end

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_q); // R6
  AST_W1C_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr == A_FLG && bus_wdata[0] && !edg_set) |=> !edg_q); // R8
  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.fast_clr && bus_rd && addr == A_CNT && !edg_set && !wrap) |=> (!edg_q && !ovf_q)); // R9
  AST_OFF_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> (tmr_tick == presc_tick)); // R11
  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !load) |=> (cnt == $past(cnt))); // R11
endmodule

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0, presc_tick = 1'b0, tbase_tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic tmr_tick;

  always #5 clk = ~clk;

  pulse_accum dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .presc_tick(presc_tick),
    .tbase_tick(tbase_tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_tick(tmr_tick)
  );

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_en, m_gated, m_pol, m_fast, m_ovf, m_edg;
  int m_sel, m_cnt;
  bit hist[$];

  task automatic check(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", t, act, exp, n_cyc);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_gated = 0; m_pol = 0; m_fast = 0; m_ovf = 0; m_edg = 0;
    m_sel = 0; m_cnt = 0;
    hist = '{0, 0, 0};
  endtask

  // one clock: compare current outputs, then advance the reference
  task automatic cycle();
    bit s2, s3, rise, fall, ev, tr, inc, cw, dlo, dfull, etick, oset, eset, acc, oclr, eclr;
    int erd;
    #1;
    s2 = hist[1]; s3 = hist[2];
    rise = s2 && !s3; fall = !s2 && s3;
    ev = m_pol ? fall : rise;
    tr = m_pol ? rise : fall;
    inc = m_en && (m_gated ? (tbase_tick && (s2 != m_pol)) : ev);
    cw = bus_wr && bus_addr == 2'd1;
    dlo = inc && !cw && ((m_cnt % 256) == 255);
    dfull = inc && !cw && (m_cnt == 65535);
    if (!m_en || m_sel == 0) etick = presc_tick;
    else if (m_sel == 1)     etick = inc && !cw;
    else if (m_sel == 2)     etick = dlo;
    else                     etick = dfull;
    case (bus_addr)
      2'd0: erd = m_en + 2 * m_gated + 4 * m_pol + 8 * m_sel + 32 * m_fast;
      2'd1: erd = m_cnt;
      2'd2: erd = 2 * m_ovf + m_edg;
      default: erd = 0;
    endcase
    check({tag, " tick (R10)"}, tmr_tick, etick);
    check({tag, " rdata (R2)"}, bus_rdata, erd);
    oset = dfull;
    eset = m_en && (m_gated ? tr : ev);
    acc = m_fast && (bus_wr || bus_rd) && bus_addr == 2'd1;
    oclr = acc || (bus_wr && bus_addr == 2'd2 && bus_wdata[1]);
    eclr = acc || (bus_wr && bus_addr == 2'd2 && bus_wdata[0]);
    m_ovf = oset || (m_ovf && !oclr);
    m_edg = eset || (m_edg && !eclr);
    if (cw) m_cnt = bus_wdata;
    else if (inc) m_cnt = (m_cnt + 1) % 65536;
    if (bus_wr && bus_addr == 2'd0) begin
      m_en = bus_wdata[0]; m_gated = bus_wdata[1]; m_pol = bus_wdata[2];
      m_sel = bus_wdata[4:3]; m_fast = bus_wdata[5];
    end
    hist.push_front(pin_in);
    void'(hist.pop_back());
    @(posedge clk);
    @(negedge clk);
    n_cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr_reg(int a, int d);
    bus_addr = a[1:0]; bus_wdata = d[15:0]; bus_wr = 1;
    cycle();
    bus_wr = 0;
  endtask

  task automatic rd_reg(int a);
    bus_addr = a[1:0]; bus_rd = 1;
    cycle();
    bus_rd = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pin_in = ~pin_in; idle(2);
      pin_in = ~pin_in; idle(2);
    end
    idle(3);
  endtask

  task automatic peek(int a, string t, int exp);
    bus_addr = a[1:0];
    #1;
    check(t, bus_rdata, exp);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      if (n_cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    tag = "R1";
    peek(0, "R1 ctrl after reset", 0);
    peek(1, "R1 count after reset", 0);
    peek(2, "R1 flags after reset", 0);
    presc_tick = 1; idle(2); presc_tick = 0; idle(2);
    // R2 control field layout, R4 rising event counting, R3 sync latency
    tag = "R2";
    wr_reg(0, 16'h0001); rd_reg(0);
    tag = "R4";
    pulses(10);
    peek(1, "R4 ten rising edges counted", 10);
    tag = "R3";
    pin_in = ~pin_in; idle(4); pin_in = ~pin_in; idle(4);
    // falling polarity
    tag = "R4";
    wr_reg(0, 16'h0005); pulses(6);
    // R13 load collides with advances
    tag = "R13";
    wr_reg(1, 16'h1234);
    for (int i = 0; i < 8; i++) begin
      pin_in = ~pin_in; bus_addr = 1; bus_wdata = 16'h0100 + i[15:0]; bus_wr = 1; cycle(); bus_wr = 0; idle(1);
    end
    // R6 wrap and R10 clock selects
    tag = "R6";
    wr_reg(0, 16'h0009); wr_reg(1, 16'hFFFE); pulses(4);
    tag = "R10";
    wr_reg(0, 16'h0011); wr_reg(1, 16'h00FE); pulses(4);
    wr_reg(0, 16'h0019); wr_reg(1, 16'hFFFD); pulses(5);
    presc_tick = 1; wr_reg(0, 16'h0001); idle(2); presc_tick = 0;
    // R8 write-one-to-clear
    tag = "R8";
    wr_reg(2, 0); rd_reg(2);
    wr_reg(2, 1); rd_reg(2);
    wr_reg(2, 2); rd_reg(2);
    pulses(1); wr_reg(2, 3); idle(2);
    // R9 fast clear
    tag = "R9";
    wr_reg(1, 16'hFFFF); pulses(1);
    rd_reg(1); rd_reg(2);
    wr_reg(0, 16'h0021); rd_reg(2); rd_reg(1); rd_reg(2);
    pulses(1); wr_reg(1, 16'h0042); rd_reg(2);
    // R5 gated mode and R7 trailing edge flag
    tag = "R5";
    wr_reg(0, 16'h0003); wr_reg(2, 3);
    tbase_tick = 1; pin_in = 1; idle(12); pin_in = 0; idle(6);
    tag = "R7";
    for (int i = 0; i < 20; i++) begin tbase_tick = i[0]; pin_in = (i < 10); cycle(); end
    wr_reg(0, 16'h0007); wr_reg(2, 3);
    for (int i = 0; i < 20; i++) begin tbase_tick = i[0]; pin_in = (i >= 10); cycle(); end
    tbase_tick = 0; idle(4);
    // R11 disabled
    tag = "R11";
    wr_reg(0, 16'h0018); presc_tick = 1; pulses(3); presc_tick = 0; pulses(2);
    // R12 mixed random activity with control rewrites
    tag = "R12";
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom;
      pin_in = (r[3:0] < 4) ? ~pin_in : pin_in;
      presc_tick = r[4]; tbase_tick = r[5];
      bus_addr = r[7:6]; bus_rd = r[8] & r[9];
      bus_wr = (r[12:10] == 0);
      bus_wdata = (r[7:6] == 1) ? ((r[13]) ? 16'hFFFC : 16'h00FC) + 16'(r[15:14]) : r[31:16];
      if (r[7:6] == 0 && bus_wr) bus_wdata[0] = 1;
      cycle();
    end
    bus_wr = 0; bus_rd = 0; idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule